// File: doc/BRIEF.md
# Horizontal Sync and Scaled Column Counter

This block produces the per-line horizontal timing for a 640-pixel-wide active picture at a 25 MHz pixel clock. It generates three things:

- an active-low horizontal sync;
- a display enable that is high while visible pixels are being sent;
- a one-clock end-of-line tick that a vertical timing block can count.

A five-state machine steps through the line. The states are a one-clock line-start state, the rest of the visible interval, the front porch, the sync pulse and the back porch. Together they last 800 clocks.

The block also outputs a column coordinate for a stored image 128 columns wide. That coordinate advances once for every 5 visible pixels, so each stored column covers 5 screen pixels. Downstream logic uses it directly as the low part of a memory address.

Top module: `hsync_column_gen`

## Requirements
Pixel index k counts clocks from the start of a line, starting at 0. The first clock after the synchronous reset is released is k = 0.
- R1: While reset is held, and at k = 0, the outputs are de_o = 1, hsync_n_o = 1, col_o = 0 and eol_o = 0.
- R2: A line lasts exactly 800 clocks. eol_o is high for exactly one clock, at k = 799, and the next clock is k = 0 of a new line.
- R3: de_o is 1 for k = 0..639 and 0 for k = 640..799.
- R4: hsync_n_o is 0 only for k = 656..751, which is 96 clocks after a 16-clock front porch. It is 1 at every other k, including the 48-clock back porch k = 752..799.
- R5: For k = 0..639, col_o equals floor(k / 5), so it runs 0 to 127 and each value lasts 5 clocks.
- R6: For k = 640..799, col_o holds at 127. It returns to 0 at k = 0 of the next line.
- R7: Asserting the synchronous reset in the middle of a line returns the block to k = 0 of a fresh line, with every counter cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n_o | output | 1 | Horizontal sync, active low |
| de_o | output | 1 | Horizontal display enable |
| col_o | output | 7 | Scaled column index, 0..127 |
| eol_o | output | 1 | One-clock end-of-line tick |

## Verification
A state machine that leaves a state early or late moves the display-enable fall or the sync window within that same line. It also stretches or shortens the 800-clock period, and the error then shows as an eol_o tick in the wrong cycle.

A prescaler that is off by one makes col_o step at the wrong pixel within the first 5 to 10 visible clocks of a line. It also makes col_o overrun or fall short of 127 by the end of the visible interval.

A column counter that is not cleared at line start shows up on the first visible pixel of the following line.

// File: rtl/hsc_pkg.sv
package hsc_pkg;

  typedef enum logic [2:0] {
    ST_LINE  = 3'd0,   // first visible clock of a line
    ST_DISP  = 3'd1,   // remaining visible clocks
    ST_FRONT = 3'd2,
    ST_SYNC  = 3'd3,
    ST_BACK  = 3'd4
  } hsc_state_e;

  // Number of clocks spent in a state.
  function automatic int unsigned hsc_len(hsc_state_e st, int unsigned act,
                                          int unsigned fp, int unsigned sp,
                                          int unsigned bp);
    case (st)
      ST_LINE:  return 1;
      ST_DISP:  return act - 1;
      ST_FRONT: return fp;
      ST_SYNC:  return sp;
      default:  return bp;
    endcase
  endfunction

  function automatic hsc_state_e hsc_next(hsc_state_e st);
    case (st)
      ST_LINE:  return ST_DISP;
      ST_DISP:  return ST_FRONT;
      ST_FRONT: return ST_SYNC;
      ST_SYNC:  return ST_BACK;
      default:  return ST_LINE;
    endcase
  endfunction

  function automatic int unsigned hsc_max4(int unsigned a, int unsigned b,
                                           int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/hsc_phase_fsm.sv
module hsc_phase_fsm
  import hsc_pkg::*;
#(
  parameter int unsigned ACTIVE = 640,
  parameter int unsigned FRONT  = 16,
  parameter int unsigned SYNC   = 96,
  parameter int unsigned BACK   = 48
) (
  input  logic       clk,
  input  logic       rst,
  output hsc_state_e state_o,
  output logic       eol_o
);
  localparam int unsigned MAXLEN = hsc_max4(ACTIVE, FRONT, SYNC, BACK);
  localparam int CNT_W = $clog2(MAXLEN + 1);

  hsc_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic             state_done;

  assign len_m1     = CNT_W'(hsc_len(state_q, ACTIVE, FRONT, SYNC, BACK) - 1);
  assign state_done = (cnt_q == len_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_LINE;
      cnt_q   <= '0;
    end else if (state_done) begin
      state_q <= hsc_next(state_q);
      cnt_q   <= '0;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
  assign eol_o   = (state_q == ST_BACK) && state_done;

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= len_m1) else $error("phase counter beyond state length"); // R2

  AST_BACK_TO_LINE: assert property (@(posedge clk) disable iff (rst)
    eol_o |=> state_q == ST_LINE) else $error("line did not restart"); // R2

endmodule

// File: rtl/hsc_col_scaler.sv
module hsc_col_scaler #(
  parameter int unsigned SCALE = 5,
  parameter int unsigned COLS  = 128,
  localparam int COL_W = $clog2(COLS),
  localparam int PRE_W = (SCALE > 1) ? $clog2(SCALE) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             de_i,
  input  logic             restart_i,
  output logic [COL_W-1:0] col_o
);
  logic [PRE_W-1:0] pre_q;
  logic [COL_W-1:0] col_q;
  logic             pre_wrap;
  logic             col_at_max;

  assign pre_wrap   = (pre_q == PRE_W'(SCALE - 1));
  assign col_at_max = (col_q == COL_W'(COLS - 1));

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pre_q <= '0;
      col_q <= '0;
    end else if (de_i) begin
      if (pre_wrap) begin
        pre_q <= '0;
        if (!col_at_max) col_q <= col_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign col_o = col_q;

  AST_COL_HOLD_BLANK: assert property (@(posedge clk) disable iff (rst)
    (!de_i && !restart_i) |=> $stable(col_q)) else $error("column moved in blanking"); // R6

  AST_COL_RESTART: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> col_q == '0) else $error("column not cleared"); // R6

endmodule

// File: rtl/hsync_column_gen.sv
module hsync_column_gen
  import hsc_pkg::*;
#(
  parameter int unsigned ACTIVE = 640,
  parameter int unsigned FRONT  = 16,
  parameter int unsigned SYNC   = 96,
  parameter int unsigned BACK   = 48,
  parameter int unsigned SCALE  = 5,
  parameter int unsigned COLS   = 128,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  output logic             hsync_n_o,
  output logic             de_o,
  output logic [COL_W-1:0] col_o,
  output logic             eol_o
);
  hsc_state_e state;
  logic       eol;
  logic       de;

  hsc_phase_fsm #(
    .ACTIVE(ACTIVE), .FRONT(FRONT), .SYNC(SYNC), .BACK(BACK)
  ) u_fsm (
    .clk(clk), .rst(rst), .state_o(state), .eol_o(eol)
  );

  assign de = (state == ST_LINE) || (state == ST_DISP);

  hsc_col_scaler #(
    .SCALE(SCALE), .COLS(COLS)
  ) u_scaler (
    .clk(clk), .rst(rst), .de_i(de), .restart_i(eol), .col_o(col_o)
  );

  assign de_o      = de;
  assign hsync_n_o = (state != ST_SYNC);
  assign eol_o     = eol;

  AST_SYNC_IN_BLANK: assert property (@(posedge clk) disable iff (rst)
    !hsync_n_o |-> !de_o) else $error("sync overlaps display"); // R4

  AST_EOL_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    eol_o |=> !eol_o) else $error("end-of-line wider than one clock"); // R2

  AST_LINE_START: assert property (@(posedge clk) disable iff (rst)
    eol_o |=> (de_o && col_o == '0)) else $error("bad line start"); // R1

endmodule

// File: tb/hsync_column_gen_bench.sv
module hsync_column_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_n, de, eol;
  logic [6:0] col;
  int         n_checks = 0;
  int         n_errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  hsync_column_gen u_hsync_column_gen (
    .clk(clk), .rst(rst), .hsync_n_o(hsync_n), .de_o(de),
    .col_o(col), .eol_o(eol)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Expected outputs for pixel k, computed from the requirements.
  task automatic check_pixel(input int k);
    int exp_de, exp_hs, exp_col, exp_eol;
    exp_de  = (k < 640) ? 1 : 0;
    exp_hs  = (k >= 656 && k < 752) ? 0 : 1;
    exp_col = (k < 640) ? k / 5 : 127;
    exp_eol = (k == 799) ? 1 : 0;
    check(de == exp_de[0], "R3 de", de, exp_de);
    check(hsync_n == exp_hs[0], "R4 hsync_n", hsync_n, exp_hs);
    check(int'(col) == exp_col, (k < 640) ? "R5 col" : "R6 col", col, exp_col);
    check(eol == exp_eol[0], "R2 eol", eol, exp_eol);
  endtask

  // Sample each pixel at the falling edge, starting with the current one.
  task automatic run_pixels(input int first, input int count);
    for (int i = 0; i < count; i++) begin
      if (i != 0) @(negedge clk);
      check_pixel((first + i) % 800);
    end
  endtask

  task automatic t_reset_state();
    repeat (3) @(negedge clk);
    check(de == 1'b1, "R1 de", de, 1);
    check(hsync_n == 1'b1, "R1 hsync_n", hsync_n, 1);
    check(col == 7'd0, "R1 col", col, 0);
    check(eol == 1'b0, "R1 eol", eol, 0);
    rst = 1'b0;
  endtask

  task automatic t_lines();
    // pixel 0 is the current cycle; three full lines plus the next start
    run_pixels(0, 3 * 800 + 1);
  endtask

  task automatic t_midline_reset();
    @(negedge clk);
    run_pixels(1, 299);
    rst = 1'b1;
    @(negedge clk);
    check(de == 1'b1 && col == 7'd0 && hsync_n == 1'b1 && eol == 1'b0,
          "R7 reset mid-line", col, 0);
    @(negedge clk);
    rst = 1'b0;
    check(col == 7'd0, "R7 col after reset", col, 0);
    run_pixels(0, 800 + 6);
  endtask

  initial begin
    t_reset_state();
    t_lines();
    t_midline_reset();
    done = 1'b1;
  end

  initial begin
    int cycles = 0;
    while (!done && cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) check(1'b0, "watchdog", cycles, 0);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule